// File: doc/BRIEF.md
# Truncated Two's-Complement Array Multiplier

This block multiplies two signed N-bit operands in one combinational pass and returns a shortened product. The partial-product terms that would fall in the R lowest columns of the product matrix are never built. A correction constant is computed when the design is elaborated and stands in for their average weight. It also supplies a half-LSB rounding term. The formed columns and the constants are then summed. The K lowest bits of that sum are dropped, so the result has 2N−R−K bits, which is N bits when R+K equals N.

The block is meant to sit in the datapath of a filter. There, each coefficient has been pre-scaled to the left by a small amount S, and the product is later shifted right by S outside this block. A shift-code input carries S. For S greater than zero, the block places the rounding bit for that later shift inside the matrix, so no separate rounding adder is needed. Sign handling uses inverted terms on the sign row and sign column plus two fixed ones, so the truncated sum stays a correct two's-complement value.

Top module: `trunc_smul`

## Requirements
- R1: The product output is 2N−R−K bits wide and carries no unknown bits for known inputs. The parameters must satisfy K ≥ 1, R+K ≤ N, and R+K+2^SW−2 ≤ 2N−1; elaboration rejects other values.
- R2: Let a_i and b_j be the raw operand bits. Let U = Σ a_i·b_j·2^(i+j) over all pairs with i+j < R. Let M = Σ_{c<R} (c+1)·2^c, and let CU = ⌊(M + 2^(R+1)) / 2^(R+2)⌋ + 2^(K−1). Then the product equals ⌊(A·B − U + CU·2^R + G) / 2^(R+K)⌋ as a signed value, where A and B are the signed operands and G is the rounding term of R5.
- R3: The operands and the product are two's complement. For example, (−1)·1 and (−1)·(−1) follow the R2 formula with signed A and B. Large positive products give a non-negative output, and large negative products give a negative output.
- R4: The error E = prod·2^(R+K) − (A·B + G) always satisfies CU·2^R − M − 2^(R+K) < E ≤ CU·2^R.
- R5: Shift code value 0 adds nothing (G = 0). A shift code S from 1 to 2^SW−1 adds G = 2^(R+K+S−1), which is output bit S−1. With both operands zero in the default configuration, codes 1, 2 and 3 give outputs 1, 2 and 4.
- R6: Over all operand pairs, the mean of E / 2^(R+K) has magnitude at most 0.25.
- R7: The most negative operand squared does not wrap. In the default configuration it gives +64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | Signed multiplicand |
| op_b | input | N | Signed multiplier (pre-shifted coefficient) |
| shift_code | input | SW | Later right-shift amount S; 0 means no extra rounding bit |
| prod | output | 2N−R−K | Signed truncated, corrected and rounded product |

## Verification
The bench builds two instances. The first uses N=8, R=6, K=2, whose output has the operand width; all 65,536 operand pairs are applied to it, with the shift code tied to the operand values. The second uses N=6, R=2, K=3; all operand pairs and all four shift codes are swept, which covers a correction constant dominated by the half-LSB term rather than the unformed weight. Together the two sweeps reach every extreme operand and the worst-case unformed carries, and they check the exact output, the error window and the mean bias.

// File: rtl/trunc_mul_pkg.sv
package trunc_mul_pkg;

   // Sum over the unformed columns c < r of (c+1)*2^c: the full weight
   // those columns would carry if every term in them were one.
   function automatic longint unformed_weight(input int r);
      longint acc;
      acc = 0;
      for (int c = 0; c < r; c++) begin
         acc = acc + (longint'(c + 1) << c);
      end
      return acc;
   endfunction

   // Correction in units of the lowest formed column: the mean of the
   // unformed terms (a quarter of the full weight), rounded to that column,
   // plus half an output LSB.
   function automatic longint corr_units(input int r, input int k);
      longint mean_units;
      mean_units = (unformed_weight(r) + (longint'(1) << (r + 1))) >> (r + 2);
      return mean_units + (longint'(1) << (k - 1));
   endfunction

endpackage

// File: rtl/tmul_matrix.sv
// Builds every formed partial-product row of a signed array multiplier.
// Row j holds the terms a_i * b_j at global column i+j; only the columns
// at or above R exist, so each row is FW = 2N-R bits wide.
module tmul_matrix #(
   parameter int N = 8,
   parameter int R = 6
) (
   input  logic [N-1:0]     a,
   input  logic [N-1:0]     b,
   output logic [2*N-R-1:0] rows [N]
);

   localparam int FW = 2 * N - R;

   for (genvar j = 0; j < N; j++) begin : g_row
      for (genvar c = 0; c < FW; c++) begin : g_col
         localparam int GCOL = c + R;
         localparam int IDX  = GCOL - j;
         if (IDX >= 0 && IDX < N) begin : g_term
            // Terms pairing exactly one sign bit carry negative weight and
            // are formed inverted; the fixed ones in tmul_const restore it.
            localparam bit INV = (IDX == N - 1) != (j == N - 1);
            if (INV) begin : g_nand
               assign rows[j][c] = ~(a[IDX] & b[j]);
            end else begin : g_and
               assign rows[j][c] = a[IDX] & b[j];
            end
         end else begin : g_empty
            assign rows[j][c] = 1'b0;
         end
      end
   end

endmodule

// File: rtl/tmul_const.sv
// Constant rows injected into the matrix: the sign-handling ones, the
// elaboration-time correction for the unformed columns, and the rounding
// bit chosen by the later right-shift amount.
module tmul_const #(
   parameter int N  = 8,
   parameter int R  = 6,
   parameter int K  = 2,
   parameter int SW = 2
) (
   input  logic [SW-1:0]    shift_code,
   output logic [2*N-R-1:0] cvec,
   output logic [2*N-R-1:0] rvec
);

   localparam int FW = 2 * N - R;

   // Fixed ones for signed operation sit at global columns N and 2N-1.
   localparam logic [FW-1:0] SIGN_VEC =
      (FW'(1) << (N - R)) | (FW'(1) << (FW - 1));

   localparam logic [FW-1:0] CORR_VEC =
      FW'(trunc_mul_pkg::corr_units(R, K));

   assign cvec = SIGN_VEC + CORR_VEC;

   // Rounding bit for a later shift by S: half the LSB left after the shift,
   // i.e. formed column K+S-1. Code zero adds nothing.
   always_comb begin
      rvec = '0;
      if (shift_code != '0) begin
         rvec = FW'(1) << (K - 1 + int'(shift_code));
      end
   end

endmodule

// File: rtl/tmul_colsum.sv
// Sums the formed rows and the constant rows column by column, modulo
// 2^FW, and returns the bits above the K dropped columns.
module tmul_colsum #(
   parameter int FW = 10,
   parameter int NR = 10,
   parameter int K  = 2
) (
   input  logic [FW-1:0]   terms [NR],
   output logic [FW-K-1:0] sum_hi
);

   logic [FW-1:0] acc;

   always_comb begin
      acc = '0;
      for (int q = 0; q < NR; q++) begin
         acc = acc + terms[q];
      end
   end

   assign sum_hi = acc[FW-1:K];

endmodule

// File: rtl/trunc_smul.sv
// Truncated two's-complement array multiplier, N x N -> 2N-R-K bits.
module trunc_smul #(
   parameter int N  = 8,
   parameter int R  = 6,
   parameter int K  = 2,
   parameter int SW = 2
) (
   input  logic [N-1:0]       op_a,
   input  logic [N-1:0]       op_b,
   input  logic [SW-1:0]      shift_code,
   output logic [2*N-R-K-1:0] prod
);

   localparam int FW = 2 * N - R;
   localparam int NR = N + 2;

   // Elaboration-time parameter checks (R1).
   initial begin
      AST_PARAM_K_MIN: assert (K >= 1)
         else $error("trunc_smul: K must be at least 1");
      AST_PARAM_WIDTH: assert (R >= 0 && R + K <= N)
         else $error("trunc_smul: R+K must not exceed N");
      AST_PARAM_ROUND: assert (R + K + (2 ** SW) - 2 <= 2 * N - 1)
         else $error("trunc_smul: rounding column out of range");
      AST_PARAM_RANGE: assert (N >= 2 && N <= 30)
         else $error("trunc_smul: N outside supported range");
   end

   logic [FW-1:0] pp_rows [N];
   logic [FW-1:0] cvec;
   logic [FW-1:0] rvec;
   logic [FW-1:0] terms   [NR];

   tmul_matrix #(
      .N (N),
      .R (R)
   ) u_matrix (
      .a    (op_a),
      .b    (op_b),
      .rows (pp_rows)
   );

   tmul_const #(
      .N  (N),
      .R  (R),
      .K  (K),
      .SW (SW)
   ) u_const (
      .shift_code (shift_code),
      .cvec       (cvec),
      .rvec       (rvec)
   );

   always_comb begin
      for (int j = 0; j < N; j++) begin
         terms[j] = pp_rows[j];
      end
      terms[N]     = cvec;
      terms[N + 1] = rvec;
   end

   tmul_colsum #(
      .FW (FW),
      .NR (NR),
      .K  (K)
   ) u_colsum (
      .terms  (terms),
      .sum_hi (prod)
   );

endmodule

// File: rtl/trunc_smul_chk.sv
// Checker for trunc_smul: relates the truncated output to the exact signed
// product computed independently by multiplication.
module trunc_smul_chk #(
   parameter int N  = 8,
   parameter int R  = 6,
   parameter int K  = 2,
   parameter int SW = 2
) (
   input logic [N-1:0]       op_a,
   input logic [N-1:0]       op_b,
   input logic [SW-1:0]      shift_code,
   input logic [2*N-R-K-1:0] prod
);

   localparam int     T     = R + K;
   localparam longint M_W   = trunc_mul_pkg::unformed_weight(R);
   localparam longint CV    = trunc_mul_pkg::corr_units(R, K) << R;
   localparam longint ONE_T = longint'(1) << T;
   localparam longint THR   = M_W + CV + (longint'(1) << (T + (2 ** SW)));

   longint sa, sb, pe, rnd, ps, err;

   always_comb begin
      sa  = longint'($signed(op_a));
      sb  = longint'($signed(op_b));
      pe  = sa * sb;
      rnd = (shift_code == '0) ? 0 : (longint'(1) << (T - 1 + int'(shift_code)));
      ps  = longint'($signed(prod));
      err = (ps <<< T) - (pe + rnd);
      if (!$isunknown({op_a, op_b, shift_code})) begin
         AST_KNOWN_OUT: assert (!$isunknown(prod)); // R1
         AST_ERR_WINDOW: assert (err <= CV && err > CV - M_W - ONE_T); // R4
         if (op_a == '0 || op_b == '0) begin
            AST_ZERO_OPERAND: assert (ps == ((CV + rnd) >>> T)); // R2
         end
         if (pe >= THR) begin
            AST_SIGN_POS: assert (ps >= 0); // R3
         end
         if (pe <= -THR) begin
            AST_NO_OVERFLOW: assert (ps < 0); // R7
         end
      end
   end

endmodule

bind trunc_smul trunc_smul_chk #(
   .N  (N),
   .R  (R),
   .K  (K),
   .SW (SW)
) u_chk (
   .op_a       (op_a),
   .op_b       (op_b),
   .shift_code (shift_code),
   .prod       (prod)
);

// File: tb/sim_trunc_smul.sv
module sim_trunc_smul;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 200000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #(CLK_PERIOD / 2) clk = ~clk;

   // Instance under test with default parameters: N=8 R=6 K=2
   logic [7:0] a0 = '0, b0 = '0;
   logic [1:0] s0 = '0;
   logic [7:0] prod0;
   trunc_smul u0 (.op_a(a0), .op_b(b0), .shift_code(s0), .prod(prod0));

   // Second configuration: N=6 R=2 K=3
   logic [5:0] a1 = '0, b1 = '0;
   logic [1:0] s1 = '0;
   logic [6:0] prod1;
   trunc_smul #(.N(6), .R(2), .K(3), .SW(2)) u1 (
      .op_a(a1), .op_b(b1), .shift_code(s1), .prod(prod1));

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  done     = 0;
   real mean_acc0 = 0.0, mean_acc1 = 0.0;

   function automatic longint sval(int n, longint v);
      return (v >= (longint'(1) << (n - 1))) ? v - (longint'(1) << n) : v;
   endfunction

   function automatic longint full_w(int r);
      longint m = 0;
      for (int c = 0; c < r; c++) m += longint'(c + 1) << c;
      return m;
   endfunction

   function automatic longint cv_of(int r, int k);
      return (((full_w(r) + (longint'(1) << (r + 1))) >> (r + 2))
              + (longint'(1) << (k - 1))) << r;
   endfunction

   function automatic longint rnd_of(int r, int k, int s);
      return (s == 0) ? 0 : (longint'(1) << (r + k + s - 1));
   endfunction

   // Behavioural model of R2
   function automatic longint model(int n, int r, int k, longint a, longint b, int s);
      longint u = 0;
      for (int i = 0; i < n; i++)
         for (int j = 0; j < n; j++)
            if (i + j < r)
               u += (((a >> i) & 1) & ((b >> j) & 1)) << (i + j);
      return (sval(n, a) * sval(n, b) - u + cv_of(r, k) + rnd_of(r, k, s)) >>> (r + k);
   endfunction

   task automatic check(string tag, longint got, longint exp);
      n_checks++;
      if (got != exp) begin
         n_fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
      end
   endtask

   // R4 window check; returns scaled error through mean accumulator
   task automatic check_window(string tag, int n, int r, int k, longint a, longint b,
                               int s, longint got, output real e_lsb);
      longint e, hi, lo;
      e  = (got <<< (r + k)) - (sval(n, a) * sval(n, b) + rnd_of(r, k, s));
      hi = cv_of(r, k);
      lo = cv_of(r, k) - full_w(r) - (longint'(1) << (r + k));
      e_lsb = real'(e) / real'(longint'(1) << (r + k));
      n_checks++;
      if (!(e <= hi && e > lo)) begin
         n_fails++;
         $display("FAIL %s actual=%0d expected=(%0d,%0d]", tag, e, lo, hi);
      end
   endtask

   task automatic vec0(int a, int b, int s, string tag, output real e_lsb);
      longint got;
      @(posedge clk);
      a0 = 8'(a); b0 = 8'(b); s0 = 2'(s);
      @(negedge clk);
      got = longint'($signed(prod0));
      check(tag, got, model(8, 6, 2, a, b, s));
      check_window("R4 u0 window", 8, 6, 2, a, b, s, got, e_lsb);
   endtask

   task automatic vec1(int a, int b, int s, string tag, output real e_lsb);
      longint got;
      @(posedge clk);
      a1 = 6'(a); b1 = 6'(b); s1 = 2'(s);
      @(negedge clk);
      got = longint'($signed(prod1));
      check(tag, got, model(6, 2, 3, a, b, s));
      check_window("R4 u1 window", 6, 2, 3, a, b, s, got, e_lsb);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL R2 watchdog actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      real e;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // Idle state with zero inputs: model gives 0 (R2)
      check("R2 idle output u0", longint'($signed(prod0)), 0);
      check("R2 idle output u1", longint'($signed(prod1)), model(6, 2, 3, 0, 0, 0));
      rst = 1'b0;

      // R1 output widths
      check("R1 width u0", $bits(prod0), 8);
      check("R1 width u1", $bits(prod1), 7);

      // R5 rounding bit position, default config, zero operands
      vec0(0, 0, 0, "R5 code0", e); check("R5 code0 literal", longint'($signed(prod0)), 0);
      vec0(0, 0, 1, "R5 code1", e); check("R5 code1 literal", longint'($signed(prod0)), 1);
      vec0(0, 0, 2, "R5 code2", e); check("R5 code2 literal", longint'($signed(prod0)), 2);
      vec0(0, 0, 3, "R5 code3", e); check("R5 code3 literal", longint'($signed(prod0)), 4);

      // R3 sign cases
      vec0(8'hFF, 8'h01, 0, "R3 minus1 times 1", e);
      vec0(8'hFF, 8'hFF, 0, "R3 minus1 times minus1", e);
      vec0(8'h7F, 8'h80, 0, "R3 max times min", e);
      check("R3 max times min sign", longint'(prod0[7]), 1);

      // R7 extreme operand squared
      vec0(8'h80, 8'h80, 0, "R7 min squared", e);
      check("R7 min squared literal", longint'($signed(prod0)), 64);
      vec1(6'h20, 6'h20, 0, "R7 min squared u1", e);

      // R2/R4/R6 exhaustive sweep, default configuration
      mean_acc0 = 0.0;
      for (int ai = 0; ai < 256; ai++) begin
         for (int bi = 0; bi < 256; bi++) begin
            vec0(ai, bi, (ai + bi) & 3, "R2 u0 sweep", e);
            mean_acc0 += e;
         end
      end
      n_checks++;
      if (!((mean_acc0 / 65536.0) <= 0.25 && (mean_acc0 / 65536.0) >= -0.25)) begin
         n_fails++;
         $display("FAIL R6 u0 mean actual=%f expected=|x|<=0.25", mean_acc0 / 65536.0);
      end

      // R2/R4/R5/R6 exhaustive sweep with all shift codes, second configuration
      mean_acc1 = 0.0;
      for (int idx = 0; idx < 16384; idx++) begin
         vec1(idx & 63, (idx >> 6) & 63, (idx >> 12) & 3, "R2 u1 sweep", e);
         mean_acc1 += e;
      end
      n_checks++;
      if (!((mean_acc1 / 16384.0) <= 0.25 && (mean_acc1 / 16384.0) >= -0.25)) begin
         n_fails++;
         $display("FAIL R6 u1 mean actual=%f expected=|x|<=0.25", mean_acc1 / 16384.0);
      end

      done = 1;
      summary();
      $finish;
   end

endmodule